// File: doc/BRIEF.md
# Service Button Gesture Controller

This block watches a single active-low service push button and sorts each press into one of three gestures. A brief press lights a status indicator for a fixed time. A long hold during normal running asks the system to reboot. A hold that was already in progress when reset ended asks for a factory restore and then a reboot. All timing is counted in ticks of an external one-millisecond strobe, so the block runs at any clock frequency.

The raw button is first synchronised and then filtered. A level only counts once it has stayed unchanged for a set number of ticks. Gesture timing works on the filtered level. The indicator output is on during the timed window and whenever the error-present input is high. A two-bit colour code goes with it. The block does not serialise the colour to any LED protocol and does not erase configuration. It only issues single-cycle request pulses for other logic to act on.

Top module: `svc_button_ctrl`

## Requirements
- R1: While reset is held, and in the first cycle after it, the indicator is off, the colour code is 0 and neither request pulse is high.
- R2: The button is active low (0 = pressed). A level change only takes effect after the synchronised input has stayed unchanged for 20 consecutive ticks. A shorter glitch produces no gesture and no output change.
- R3: A filtered press released after fewer than 1000 ticks turns on the indicator for exactly 10000 ticks. The window starts in the cycle after the release is recognised.
- R4: The colour code is 2'b01 (healthy) when the indicator is on and the error input is low. It is 2'b10 (error) whenever the error input is high. It is 2'b00 when the indicator is off.
- R5: Outside the timed window the indicator is on exactly when the error input is high.
- R6: A filtered hold reaching 5000 ticks during normal running gives one reboot pulse, one clock wide, with no repeat until the button is released.
- R7: A filtered press released after at least 1000 ticks but before 5000 ticks produces no request and does not light the indicator.
- R8: If the first settled level after reset is pressed and the hold reaches 5000 ticks, a one-clock restore pulse is issued, followed in the very next cycle by a one-clock reboot pulse, and nothing more until release.
- R9: If such a power-up hold is released before 5000 ticks, no request is issued and later gestures behave as in normal running.
- R10: A short press completed while the window is active restarts the 10000-tick window. A restart that falls in the same cycle as the expiry wins over the expiry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| btn_n_i | input | 1 | Raw button level, 0 when pressed |
| err_i | input | 1 | Error-present flag |
| tick_i | input | 1 | One-cycle strobe once per millisecond |
| ind_on_o | output | 1 | Status indicator enable |
| colour_o | output | 2 | Indicator colour code (00 off, 01 healthy, 10 error) |
| reboot_o | output | 1 | Reboot request pulse |
| restore_o | output | 1 | Factory-restore request pulse |

## Verification
The window timer's restart by a new short press and its own expiry can land in the same clock edge. The bench provokes this by reading its reference model's remaining-window count. It releases a second press exactly as many cycles ahead of expiry as the synchroniser, filter and classifier take. The reference model rules that the restart wins. The indicator is then checked still on well past the first window's end and off once the fresh 10000-tick window has run out.

// File: rtl/svc_btn_pkg.sv
// Package: shared types and codes for the service button controller.
// Assumes a two-bit colour code; state encoding is internal.
package svc_btn_pkg;
    localparam int COLOUR_W = 2;
    typedef logic [COLOUR_W-1:0] colour_t;

    localparam colour_t CLR_OFF     = 2'b00;
    localparam colour_t CLR_HEALTHY = 2'b01;
    localparam colour_t CLR_ERROR   = 2'b10;

    typedef enum logic [2:0] {
        GS_BOOT,
        GS_IDLE,
        GS_PRESS,
        GS_WAIT_REL,
        GS_PWR_HOLD,
        GS_PWR_REBOOT
    } gest_state_t;
endpackage

// File: rtl/svc_btn_filter.sv
// Module: svc_btn_filter
// Synchronises the active-low raw button into the clock domain and
// accepts a new level only after it has been unchanged for DEB_MS ticks.
// Assumes tick_i is a one-cycle strobe; SYNC_STAGES >= 2, DEB_MS >= 2.
// settled_o rises with the first accepted level after reset and stays high.
module svc_btn_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int DEB_MS      = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic btn_n_i,
    output logic pressed_o,
    output logic settled_o
);
    localparam int CW = $clog2(DEB_MS);
    localparam logic [CW-1:0] CNT_LAST = CW'(DEB_MS - 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   synced;
    logic                   cand_q;
    logic [CW-1:0]          cnt_q;

    assign synced = sync_q[SYNC_STAGES-1];

    // Purpose: shift the inverted raw level through the synchroniser.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], ~btn_n_i};
    end

    // Purpose: track the candidate level and accept it once stable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cand_q    <= 1'b0;
            cnt_q     <= '0;
            pressed_o <= 1'b0;
            settled_o <= 1'b0;
        end else if (synced != cand_q) begin
            cand_q <= synced;
            cnt_q  <= '0;
        end else if (tick_i) begin
            if (cnt_q == CNT_LAST) begin
                pressed_o <= cand_q;
                settled_o <= 1'b1;
                cnt_q     <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/svc_btn_gesture.sv
// Module: svc_btn_gesture
// Classifies filtered presses into short press, run-time long hold and
// power-up hold, emitting registered single-cycle event pulses.
// Assumes SHORT_MS < HOLD_MS; one counter serves both kinds of hold.
module svc_btn_gesture
    import svc_btn_pkg::*;
#(
    parameter int SHORT_MS = 1000,
    parameter int HOLD_MS  = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic pressed_i,
    input  logic settled_i,
    output logic short_o,
    output logic reboot_o,
    output logic restore_o
);
    localparam int HW = $clog2(HOLD_MS + 1);
    localparam logic [HW-1:0] HOLD_LAST = HW'(HOLD_MS - 1);
    localparam logic [HW-1:0] SHORT_LIM = HW'(SHORT_MS);

    gest_state_t   state_q;
    logic [HW-1:0] hcnt_q;

    // Purpose: gesture state machine with hold counter and event pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= GS_BOOT;
            hcnt_q    <= '0;
            short_o   <= 1'b0;
            reboot_o  <= 1'b0;
            restore_o <= 1'b0;
        end else begin
            short_o   <= 1'b0;
            reboot_o  <= 1'b0;
            restore_o <= 1'b0;
            case (state_q)
                GS_BOOT: begin
                    if (settled_i) begin
                        hcnt_q  <= '0;
                        state_q <= pressed_i ? GS_PWR_HOLD : GS_IDLE;
                    end
                end
                GS_IDLE: begin
                    if (pressed_i) begin
                        hcnt_q  <= '0;
                        state_q <= GS_PRESS;
                    end
                end
                GS_PRESS: begin
                    if (!pressed_i) begin
                        short_o <= (hcnt_q < SHORT_LIM);
                        state_q <= GS_IDLE;
                    end else if (tick_i) begin
                        if (hcnt_q == HOLD_LAST) begin
                            reboot_o <= 1'b1;
                            state_q  <= GS_WAIT_REL;
                        end else begin
                            hcnt_q <= hcnt_q + 1'b1;
                        end
                    end
                end
                GS_WAIT_REL: begin
                    if (!pressed_i) state_q <= GS_IDLE;
                end
                GS_PWR_HOLD: begin
                    if (!pressed_i) begin
                        state_q <= GS_IDLE;
                    end else if (tick_i) begin
                        if (hcnt_q == HOLD_LAST) begin
                            restore_o <= 1'b1;
                            state_q   <= GS_PWR_REBOOT;
                        end else begin
                            hcnt_q <= hcnt_q + 1'b1;
                        end
                    end
                end
                GS_PWR_REBOOT: begin
                    reboot_o <= 1'b1;
                    state_q  <= GS_WAIT_REL;
                end
                default: state_q <= GS_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/svc_btn_window.sv
// Module: svc_btn_window
// Timed status window started or restarted by a short-press event and
// the indicator enable and colour derived from it and the error flag.
// Assumes SHOW_MS >= 2; a restart wins over expiry in the same cycle.
module svc_btn_window
    import svc_btn_pkg::*;
#(
    parameter int SHOW_MS = 10000
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    tick_i,
    input  logic    short_i,
    input  logic    err_i,
    output logic    ind_on_o,
    output colour_t colour_o
);
    localparam int WW = $clog2(SHOW_MS);
    localparam logic [WW-1:0] SHOW_LAST = WW'(SHOW_MS - 1);

    logic          active_q;
    logic [WW-1:0] wcnt_q;

    // Purpose: run the window counter, restarting on each short press.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            wcnt_q   <= '0;
        end else if (short_i) begin
            active_q <= 1'b1;
            wcnt_q   <= '0;
        end else if (active_q && tick_i) begin
            if (wcnt_q == SHOW_LAST) begin
                active_q <= 1'b0;
                wcnt_q   <= '0;
            end else begin
                wcnt_q <= wcnt_q + 1'b1;
            end
        end
    end

    // Purpose: select indicator enable and colour code.
    always_comb begin
        ind_on_o = active_q | err_i;
        if (err_i)         colour_o = CLR_ERROR;
        else if (active_q) colour_o = CLR_HEALTHY;
        else               colour_o = CLR_OFF;
    end
endmodule

// File: rtl/svc_button_ctrl.sv
// Module: svc_button_ctrl (top)
// Service button gesture controller: filter, gesture classifier and
// status window in a chain. Assumes tick_i pulses once per millisecond.
module svc_button_ctrl
    import svc_btn_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int DEB_MS      = 20,
    parameter int SHORT_MS    = 1000,
    parameter int HOLD_MS     = 5000,
    parameter int SHOW_MS     = 10000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       btn_n_i,
    input  logic       err_i,
    input  logic       tick_i,
    output logic       ind_on_o,
    output logic [1:0] colour_o,
    output logic       reboot_o,
    output logic       restore_o
);
    logic deb_pressed;
    logic deb_settled;
    logic short_evt;

    svc_btn_filter #(
        .SYNC_STAGES(SYNC_STAGES),
        .DEB_MS     (DEB_MS)
    ) u_filter (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tick_i),
        .btn_n_i  (btn_n_i),
        .pressed_o(deb_pressed),
        .settled_o(deb_settled)
    );

    svc_btn_gesture #(
        .SHORT_MS(SHORT_MS),
        .HOLD_MS (HOLD_MS)
    ) u_gesture (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tick_i),
        .pressed_i(deb_pressed),
        .settled_i(deb_settled),
        .short_o  (short_evt),
        .reboot_o (reboot_o),
        .restore_o(restore_o)
    );

    svc_btn_window #(
        .SHOW_MS(SHOW_MS)
    ) u_window (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick_i),
        .short_i (short_evt),
        .err_i   (err_i),
        .ind_on_o(ind_on_o),
        .colour_o(colour_o)
    );
endmodule

// File: rtl/svc_button_chk.sv
// Module: svc_button_chk
// Checker bound to svc_button_ctrl: relates the filtered level, the
// short-press event and the outputs over time. No outputs of its own.
module svc_button_chk
    import svc_btn_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       pressed,
    input logic       short_evt,
    input logic       err,
    input logic       ind_on,
    input logic [1:0] colour,
    input logic       reboot,
    input logic       restore
);
    p_reboot_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        reboot |=> !reboot);

    p_reboot_from_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (reboot && !$past(restore)) |-> $past(pressed));

    p_restore_then_reboot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        restore |=> (reboot && !restore));

    p_restore_from_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        restore |-> $past(pressed));

    p_no_overlap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(restore && reboot));

    p_short_lights_r3: assert property (@(posedge clk) disable iff (!rst_n)
        short_evt |=> ind_on);

    p_err_colour_r5: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (ind_on && colour == CLR_ERROR));

    p_off_colour_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !ind_on |-> colour == CLR_OFF);
endmodule

bind svc_button_ctrl svc_button_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pressed  (deb_pressed),
    .short_evt(short_evt),
    .err      (err_i),
    .ind_on   (ind_on_o),
    .colour   (colour_o),
    .reboot   (reboot_o),
    .restore  (restore_o)
);

// File: tb/svc_button_ctrl_bench.sv
// Bench: behavioural reference model compared every cycle, plus directed
// scenario checks on pulse counts and indicator state.
module svc_button_ctrl_bench;
    localparam int DEB   = 20;
    localparam int SHORT = 1000;
    localparam int HOLD  = 5000;
    localparam int SHOW  = 10000;
    localparam int LIMIT = 190000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       btn_n = 1'b1;
    logic       err = 1'b0;
    logic       tick = 1'b0;
    logic       ind_on;
    logic [1:0] colour;
    logic       reboot;
    logic       restore;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int tick_every = 1;
    int tphase = 0;
    bit done = 0;

    int dut_reboots = 0;
    int dut_restores = 0;
    int reboot_cyc = -1;
    int restore_cyc = -1;

    always #10 clk = ~clk;

    svc_button_ctrl u_svc_button_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .btn_n_i  (btn_n),
        .err_i    (err),
        .tick_i   (tick),
        .ind_on_o (ind_on),
        .colour_o (colour),
        .reboot_o (reboot),
        .restore_o(restore)
    );

    task automatic chk_eq(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic report();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // Tick generator: strobe every tick_every cycles, driven after the edge.
    always @(posedge clk) begin
        #3;
        tphase = (tphase + 1) % tick_every;
        tick = (tphase == 0);
    end

    // Reference model state.
    bit m_q[$];
    bit m_cand, m_filt, m_settled;
    int m_run;
    int m_mode;      // 0 boot, 1 idle, 2 press, 3 wait release, 4 power hold, 5 power reboot
    int m_held;
    bit m_short, m_reboot, m_restore;
    int m_left;

    always @(posedge clk) begin
        bit tk;
        bit p;
        bit n_short, n_reboot, n_restore;
        tk = tick;
        if (!rst_n) begin
            m_q = {1'b0, 1'b0};
            m_cand = 0; m_filt = 0; m_settled = 0; m_run = 0;
            m_mode = 0; m_held = 0;
            m_short = 0; m_reboot = 0; m_restore = 0;
            m_left = 0;
        end else begin
            if (m_short) m_left = SHOW;
            else if (m_left > 0 && tk) m_left--;
            n_short = 0; n_reboot = 0; n_restore = 0;
            case (m_mode)
                0: if (m_settled) begin m_held = 0; m_mode = m_filt ? 4 : 1; end
                1: if (m_filt) begin m_held = 0; m_mode = 2; end
                2: if (!m_filt) begin
                       n_short = (m_held < SHORT); m_mode = 1;
                   end else if (tk) begin
                       m_held++;
                       if (m_held == HOLD) begin n_reboot = 1; m_mode = 3; end
                   end
                3: if (!m_filt) m_mode = 1;
                4: if (!m_filt) m_mode = 1;
                   else if (tk) begin
                       m_held++;
                       if (m_held == HOLD) begin n_restore = 1; m_mode = 5; end
                   end
                default: begin n_reboot = 1; m_mode = 3; end
            endcase
            m_short = n_short; m_reboot = n_reboot; m_restore = n_restore;
            p = m_q[0];
            void'(m_q.pop_front());
            m_q.push_back(!btn_n);
            if (p != m_cand) begin
                m_cand = p; m_run = 0;
            end else if (tk) begin
                m_run++;
                if (m_run == DEB) begin m_filt = m_cand; m_settled = 1; m_run = 0; end
            end
        end
    end

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk_eq("R3/R5 indicator", int'(ind_on), int'((m_left > 0) || err));
            chk_eq("R4 colour", int'(colour), err ? 2 : ((m_left > 0) ? 1 : 0));
            chk_eq("R6 reboot pulse", int'(reboot), int'(m_reboot));
            chk_eq("R8 restore pulse", int'(restore), int'(m_restore));
        end
        if (reboot === 1'b1)  begin dut_reboots++;  reboot_cyc = cyc; end
        if (restore === 1'b1) begin dut_restores++; restore_cyc = cyc; end
    end

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cyc++;
        if (cyc > LIMIT && !done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected<=%0d", cyc, LIMIT);
            report();
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        #3;
    endtask

    task automatic wait_left(input int v);
        do begin
            @(posedge clk);
            #1;
        end while (m_left != v);
        #2;
    endtask

    initial begin
        int rb0, rs0;
        // R1: reset state
        wait_cyc(3);
        @(negedge clk);
        chk_eq("R1 indicator in reset", int'(ind_on), 0);
        chk_eq("R1 colour in reset", int'(colour), 0);
        chk_eq("R1 pulses in reset", int'(reboot) + int'(restore), 0);

        // R8: hold from power-up
        btn_n = 1'b0;
        wait_cyc(2);
        rst_n = 1'b1;
        @(negedge clk);
        chk_eq("R1 indicator after reset", int'(ind_on), 0);
        wait_cyc(5100);
        chk_eq("R8 restore count", dut_restores, 1);
        chk_eq("R8 reboot count", dut_reboots, 1);
        chk_eq("R8 reboot follows restore", reboot_cyc, restore_cyc + 1);
        wait_cyc(1000);
        chk_eq("R8 no repeat while held", dut_restores + dut_reboots, 2);
        btn_n = 1'b1;
        wait_cyc(60);

        // R9: power-up hold released early
        rst_n = 1'b0;
        btn_n = 1'b0;
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(2000);
        btn_n = 1'b1;
        wait_cyc(100);
        chk_eq("R9 no request on early release", dut_restores + dut_reboots, 2);
        chk_eq("R9 indicator stays off", int'(ind_on), 0);
        btn_n = 1'b0; wait_cyc(100); btn_n = 1'b1; wait_cyc(50);
        chk_eq("R9 normal short press lights", int'(ind_on), 1);
        chk_eq("R4 healthy colour", int'(colour), 1);
        wait_cyc(10100);
        chk_eq("R3 window expired", int'(ind_on), 0);

        // R2: glitch shorter than the filter
        btn_n = 1'b0; wait_cyc(10); btn_n = 1'b1;
        wait_cyc(200);
        chk_eq("R2 glitch ignored", int'(ind_on), 0);

        // R5: error while idle
        err = 1'b1; wait_cyc(5);
        chk_eq("R5 error lights indicator", int'(ind_on), 1);
        chk_eq("R4 error colour", int'(colour), 2);
        err = 1'b0; wait_cyc(2);
        chk_eq("R5 indicator off without error", int'(ind_on), 0);
        chk_eq("R4 off colour", int'(colour), 0);

        // R4: error rising during the window
        btn_n = 1'b0; wait_cyc(100); btn_n = 1'b1; wait_cyc(50);
        err = 1'b1; wait_cyc(2);
        chk_eq("R4 error colour in window", int'(colour), 2);
        err = 1'b0; wait_cyc(2);
        chk_eq("R3 window still on", int'(ind_on), 1);
        chk_eq("R4 healthy colour again", int'(colour), 1);
        wait_cyc(10100);
        chk_eq("R3 window over", int'(ind_on), 0);

        // R7: medium press with a slower tick
        rb0 = dut_reboots; rs0 = dut_restores;
        tick_every = 2;
        btn_n = 1'b0; wait_cyc(4000); btn_n = 1'b1;
        wait_cyc(200);
        tick_every = 1;
        chk_eq("R7 medium press no indicator", int'(ind_on), 0);
        chk_eq("R7 medium press no request", dut_reboots + dut_restores, rb0 + rs0);

        // R6: long hold during running
        btn_n = 1'b0; wait_cyc(6000);
        chk_eq("R6 one reboot pulse", dut_reboots, rb0 + 1);
        chk_eq("R6 no restore", dut_restores, rs0);
        chk_eq("R6 indicator off", int'(ind_on), 0);
        btn_n = 1'b1; wait_cyc(100);
        chk_eq("R6 no extra pulse on release", dut_reboots, rb0 + 1);

        // R10: restart landing on the expiry cycle
        btn_n = 1'b0; wait_cyc(100); btn_n = 1'b1;
        wait_left(400);
        btn_n = 1'b0;
        wait_left(DEB + 5);
        btn_n = 1'b1;
        wait_cyc(9000);
        chk_eq("R10 window restarted", int'(ind_on), 1);
        wait_cyc(1100);
        chk_eq("R10 restarted window ends", int'(ind_on), 0);

        report();
    end
endmodule